// File: doc/BRIEF.md
# Audio clock ratio selector

This block turns a base clock-enable stream, one pulse per base tick at 512 times the audio sampling rate, into the three audio output clocks. The first is a system-clock tick stream (SCK) at 128, 256 or 512 times the sampling rate. The second is a bit clock (BCK) at 64 times the sampling rate. The third is a frame clock (LRCK) at the sampling rate. All of them are made with clock enables, and the block runs in one synchronous clock domain.

The SCK multiple comes from one of two sources. In automatic mode it follows bands of the measured sampling rate and the lock state of the recovered clock. In manual mode it follows a 3-bit code. Automatic mode always has priority over the code.

A small state machine holds the active ratio. Its states are `ST_R128`, `ST_R256` and `ST_R512`. It has two transitions: `T_HOLD` keeps the current state, and `T_SWITCH` moves to the requested ratio. `T_SWITCH` is taken only on the base tick that closes a frame, so a ratio change never truncates a clock period. An unsupported-setting flag reports a manual 512x request that had to fall back. It also reports a locked rate outside the decodable range.

Top module: `audclk_ratio_sel`

## Requirements
- R1: With `auto_en_i`=1 and `pll_lock_i`=1, the requested ratio is 512x for `fs_khz_i` <= 54, 256x for 55..107 and 128x for >= 108.
- R2: With `auto_en_i`=1 and `pll_lock_i`=0, the requested ratio is 128x for every `fs_khz_i`.
- R3: While `auto_en_i`=1, `man_code_i` has no effect on `ratio_o` or `unsup_o`.
- R4: With `auto_en_i`=0, `man_code_i` 3'b000 requests 128x and 3'b010 requests 256x. Every other code except 3'b100 requests 128x.
- R5: With `auto_en_i`=0 and `man_code_i`=3'b100, the request is 512x when `fs_khz_i` <= 108. Otherwise the request is 256x and `unsup_o` is 1 one clock later.
- R6: With `pll_lock_i`=1 and `fs_khz_i` outside 7..216, `unsup_o` is 1 one clock later. `unsup_o` is otherwise 0, except in the case of R5.
- R7: `ratio_o` encodes the active ratio as 0 for 128x, 1 for 256x and 2 for 512x. It takes the requested value only on the base tick where the frame counter wraps from 511 to 0.
- R8: `sck_tick_o` is high only in a cycle with `base_tick_i`=1. At 512x it follows every base tick. At 256x it follows the ticks where the frame position is even. At 128x it follows the ticks where the frame position is a multiple of 4.
- R9: `bck_o` has a period of 8 base ticks with 50% duty. It is low in frame positions 0..3 modulo 8.
- R10: `lrck_o` is low (left channel) for frame positions 0..255 and high for 256..511. It changes only where `bck_o` falls.
- R11: After reset, `ratio_o`=0, `bck_o`=0, `lrck_o`=0, `unsup_o`=0, and the frame position is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_tick_i | input | 1 | Enable, one pulse per 512x-rate base period |
| pll_lock_i | input | 1 | Recovered clock is locked |
| auto_en_i | input | 1 | Automatic ratio selection enable |
| fs_khz_i | input | 8 | Measured sampling rate in kHz |
| man_code_i | input | 3 | Manual ratio code |
| sck_tick_o | output | 1 | System-clock enable pulse |
| bck_o | output | 1 | Bit clock level, 64x |
| lrck_o | output | 1 | Frame clock level, low for left |
| ratio_o | output | 2 | Active SCK ratio code |
| unsup_o | output | 1 | Unsupported setting or rate flag |

## Verification
The bench builds the block with its default parameters: 8-bit rate input, band edges at 54 and 108 kHz, and a 7..216 kHz valid range. With these values, every band edge and range edge is a reachable input value. With a 512-tick frame, one frame takes a few hundred cycles. Many ratio switches and both LRCK halves can therefore be observed within a short run, including runs with gaps in the base-tick stream.

// File: rtl/audclk_pkg.sv
package audclk_pkg;

    typedef enum logic [1:0] {
        RATIO_128 = 2'd0,
        RATIO_256 = 2'd1,
        RATIO_512 = 2'd2
    } ratio_e;

    localparam logic [2:0] MAN_CODE_128 = 3'b000;
    localparam logic [2:0] MAN_CODE_256 = 3'b010;
    localparam logic [2:0] MAN_CODE_512 = 3'b100;

endpackage

// File: rtl/rate_band_sel.sv
module rate_band_sel
    import audclk_pkg::*;
#(
    parameter int FS_W        = 8,
    parameter int AUTO_LO_KHZ = 54,
    parameter int AUTO_HI_KHZ = 108,
    parameter int MAX512_KHZ  = 108,
    parameter int FS_MIN_KHZ  = 7,
    parameter int FS_MAX_KHZ  = 216
) (
    input  logic            pll_lock_i,
    input  logic            auto_en_i,
    input  logic [FS_W-1:0] fs_khz_i,
    input  logic [2:0]      man_code_i,
    output ratio_e          req_o,
    output logic            unsup_o
);

    localparam logic [FS_W-1:0] LO_EDGE  = FS_W'(AUTO_LO_KHZ);
    localparam logic [FS_W-1:0] HI_EDGE  = FS_W'(AUTO_HI_KHZ);
    localparam logic [FS_W-1:0] CAP_512  = FS_W'(MAX512_KHZ);
    localparam logic [FS_W-1:0] RANGE_LO = FS_W'(FS_MIN_KHZ);
    localparam logic [FS_W-1:0] RANGE_HI = FS_W'(FS_MAX_KHZ);

    ratio_e auto_req;
    ratio_e man_req;
    logic   man_fallback;
    logic   out_of_range;

    // Automatic band choice; an unlocked clock always gets the lowest multiple.
    always_comb begin
        if (!pll_lock_i)
            auto_req = RATIO_128;
        else if (fs_khz_i <= LO_EDGE)
            auto_req = RATIO_512;
        else if (fs_khz_i < HI_EDGE)
            auto_req = RATIO_256;
        else
            auto_req = RATIO_128;
    end

    // Manual code decode with the 512x rate ceiling.
    always_comb begin
        man_fallback = 1'b0;
        unique case (man_code_i)
            MAN_CODE_256: man_req = RATIO_256;
            MAN_CODE_512: begin
                if (fs_khz_i > CAP_512) begin
                    man_req      = RATIO_256;
                    man_fallback = 1'b1;
                end else begin
                    man_req = RATIO_512;
                end
            end
            default:      man_req = RATIO_128;
        endcase
    end

    assign out_of_range = pll_lock_i && ((fs_khz_i < RANGE_LO) || (fs_khz_i > RANGE_HI));
    assign req_o        = auto_en_i ? auto_req : man_req;
    assign unsup_o      = out_of_range || (!auto_en_i && man_fallback);

endmodule

// File: rtl/frame_phase_ctr.sv
module frame_phase_ctr #(
    parameter int BASE_MULT = 512,
    parameter int BCK_MULT  = 64,
    localparam int CNT_W    = $clog2(BASE_MULT),
    localparam int BCK_BIT  = $clog2(BASE_MULT / BCK_MULT) - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             base_tick_i,
    output logic [CNT_W-1:0] pos_o,
    output logic             frame_end_o,
    output logic             bck_o,
    output logic             lrck_o
);

    logic [CNT_W-1:0] pos_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pos_q <= '0;
        else if (base_tick_i)
            pos_q <= pos_q + 1'b1;
    end

    assign pos_o       = pos_q;
    assign frame_end_o = base_tick_i && (pos_q == {CNT_W{1'b1}});
    // Both levels come straight from counter bits, so every half period is exact
    // and the frame bit can only flip where the bit-clock bit returns to zero.
    assign bck_o       = pos_q[BCK_BIT];
    assign lrck_o      = pos_q[CNT_W-1];

endmodule

// File: rtl/ratio_fsm.sv
module ratio_fsm
    import audclk_pkg::*;
#(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             base_tick_i,
    input  logic             frame_end_i,
    input  logic [CNT_W-1:0] pos_i,
    input  ratio_e           req_i,
    output ratio_e           ratio_o,
    output logic             sck_tick_o
);

    typedef enum logic [1:0] {
        ST_R128 = 2'd0,
        ST_R256 = 2'd1,
        ST_R512 = 2'd2
    } st_e;

    st_e state_q;
    st_e state_d;
    st_e req_st;

    always_comb begin
        unique case (req_i)
            RATIO_256: req_st = ST_R256;
            RATIO_512: req_st = ST_R512;
            default:   req_st = ST_R128;
        endcase
    end

    // Transitions: T_SWITCH on a frame end, T_HOLD otherwise.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_R128,
            ST_R256,
            ST_R512: if (frame_end_i) state_d = req_st;
            default: state_d = ST_R128;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_R128;
        else
            state_q <= state_d;
    end

    // Output process: SCK tick pattern per active state.
    always_comb begin
        ratio_o    = RATIO_128;
        sck_tick_o = 1'b0;
        unique case (state_q)
            ST_R512: begin
                ratio_o    = RATIO_512;
                sck_tick_o = base_tick_i;
            end
            ST_R256: begin
                ratio_o    = RATIO_256;
                sck_tick_o = base_tick_i && !pos_i[0];
            end
            default: begin
                ratio_o    = RATIO_128;
                sck_tick_o = base_tick_i && (pos_i[1:0] == 2'b00);
            end
        endcase
    end

endmodule

// File: rtl/audclk_ratio_sel.sv
module audclk_ratio_sel
    import audclk_pkg::*;
#(
    parameter int FS_W        = 8,
    parameter int AUTO_LO_KHZ = 54,
    parameter int AUTO_HI_KHZ = 108,
    parameter int MAX512_KHZ  = 108,
    parameter int FS_MIN_KHZ  = 7,
    parameter int FS_MAX_KHZ  = 216,
    parameter int BASE_MULT   = 512,
    parameter int BCK_MULT    = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            base_tick_i,
    input  logic            pll_lock_i,
    input  logic            auto_en_i,
    input  logic [FS_W-1:0] fs_khz_i,
    input  logic [2:0]      man_code_i,
    output logic            sck_tick_o,
    output logic            bck_o,
    output logic            lrck_o,
    output logic [1:0]      ratio_o,
    output logic            unsup_o
);

    localparam int CNT_W = $clog2(BASE_MULT);

    ratio_e           req;
    ratio_e           active;
    logic             unsup_d;
    logic             unsup_q;
    logic [CNT_W-1:0] pos;
    logic             frame_end;

    rate_band_sel #(
        .FS_W        (FS_W),
        .AUTO_LO_KHZ (AUTO_LO_KHZ),
        .AUTO_HI_KHZ (AUTO_HI_KHZ),
        .MAX512_KHZ  (MAX512_KHZ),
        .FS_MIN_KHZ  (FS_MIN_KHZ),
        .FS_MAX_KHZ  (FS_MAX_KHZ)
    ) sel_i (
        .pll_lock_i (pll_lock_i),
        .auto_en_i  (auto_en_i),
        .fs_khz_i   (fs_khz_i),
        .man_code_i (man_code_i),
        .req_o      (req),
        .unsup_o    (unsup_d)
    );

    frame_phase_ctr #(
        .BASE_MULT (BASE_MULT),
        .BCK_MULT  (BCK_MULT)
    ) ctr_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .base_tick_i (base_tick_i),
        .pos_o       (pos),
        .frame_end_o (frame_end),
        .bck_o       (bck_o),
        .lrck_o      (lrck_o)
    );

    ratio_fsm #(
        .CNT_W (CNT_W)
    ) fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .base_tick_i (base_tick_i),
        .frame_end_i (frame_end),
        .pos_i       (pos),
        .req_i       (req),
        .ratio_o     (active),
        .sck_tick_o  (sck_tick_o)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            unsup_q <= 1'b0;
        else
            unsup_q <= unsup_d;
    end

    assign unsup_o = unsup_q;
    assign ratio_o = active;

endmodule

// File: rtl/audclk_ratio_sel_chk.sv
module audclk_ratio_sel_chk #(
    parameter int FS_W       = 8,
    parameter int MAX512_KHZ = 108
) (
    input logic            clk,
    input logic            rst_n,
    input logic            base_tick_i,
    input logic            pll_lock_i,
    input logic            auto_en_i,
    input logic [FS_W-1:0] fs_khz_i,
    input logic [2:0]      man_code_i,
    input logic            sck_tick_o,
    input logic            bck_o,
    input logic            lrck_o,
    input logic [1:0]      ratio_o,
    input logic            unsup_o
);

    localparam logic [FS_W-1:0] CAP = FS_W'(MAX512_KHZ);

    a_r5_fallback_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (!auto_en_i && man_code_i == 3'b100 && fs_khz_i > CAP) |=> unsup_o);

    a_r6_unlocked_auto_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_en_i && !pll_lock_i) |=> !unsup_o);

    a_r7_switch_at_frame: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ratio_o) |-> $fell(lrck_o));

    a_r7_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
        ratio_o != 2'd3);

    a_r8_sck_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        sck_tick_o |-> base_tick_i);

    a_r9_bck_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bck_o) |-> $past(base_tick_i));

    a_r10_lrck_on_bck_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lrck_o) |-> $fell(bck_o));

endmodule

bind audclk_ratio_sel audclk_ratio_sel_chk #(
    .FS_W       (FS_W),
    .MAX512_KHZ (MAX512_KHZ)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .base_tick_i (base_tick_i),
    .pll_lock_i  (pll_lock_i),
    .auto_en_i   (auto_en_i),
    .fs_khz_i    (fs_khz_i),
    .man_code_i  (man_code_i),
    .sck_tick_o  (sck_tick_o),
    .bck_o       (bck_o),
    .lrck_o      (lrck_o),
    .ratio_o     (ratio_o),
    .unsup_o     (unsup_o)
);

// File: tb/audclk_ratio_sel_tb_top.sv
`timescale 1ns/1ps
module audclk_ratio_sel_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       base_tick = 1'b0;
    logic       lock = 1'b0;
    logic       auto_en = 1'b1;
    logic [7:0] fs = 8'd48;
    logic [2:0] code = 3'b000;
    logic       sck_tick, bck, lrck, unsup;
    logic [1:0] ratio;

    int    n_checks = 0;
    int    n_errors = 0;
    bit    done = 1'b0;
    string cur_tag = "R11";

    // model state
    int   m_pos = 0;
    int   m_ratio = 0;
    logic m_unsup = 1'b0;

    always #4 clk = ~clk;

    audclk_ratio_sel dut_i (
        .clk(clk), .rst_n(rst_n), .base_tick_i(base_tick), .pll_lock_i(lock),
        .auto_en_i(auto_en), .fs_khz_i(fs), .man_code_i(code),
        .sck_tick_o(sck_tick), .bck_o(bck), .lrck_o(lrck),
        .ratio_o(ratio), .unsup_o(unsup)
    );

    function automatic int exp_req(logic a, logic l, int f, logic [2:0] c);
        if (a) begin
            if (!l) return 0;
            if (f <= 54) return 2;
            if (f < 108) return 1;
            return 0;
        end
        if (c == 3'b010) return 1;
        if (c == 3'b100) return (f <= 108) ? 2 : 1;
        return 0;
    endfunction

    function automatic logic exp_unsup(logic a, logic l, int f, logic [2:0] c);
        return (l && (f < 7 || f > 216)) || (!a && c == 3'b100 && f > 108);
    endfunction

    function automatic logic exp_sck(logic t, int r, int p);
        if (!t) return 1'b0;
        if (r == 2) return 1'b1;
        if (r == 1) return (p % 2) == 0;
        return (p % 4) == 0;
    endfunction

    task automatic chk(string tag, int act, int exp, string what);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s actual=%0d expected=%0d pos=%0d", tag, what, act, exp, m_pos);
        end
    endtask

    // One clock cycle: entered at a negedge with inputs already driven.
    task automatic cycle();
        #1;
        chk("R8", sck_tick, exp_sck(base_tick, m_ratio, m_pos), "sck_tick");
        @(posedge clk);
        m_unsup = exp_unsup(auto_en, lock, fs, code);
        if (base_tick) begin
            if (m_pos == 511) m_ratio = exp_req(auto_en, lock, fs, code);
            m_pos = (m_pos + 1) % 512;
        end
        @(negedge clk);
        chk("R9", bck, ((m_pos % 8) >= 4) ? 1 : 0, "bck");
        chk("R10", lrck, (m_pos >= 256) ? 1 : 0, "lrck");
        chk(cur_tag, ratio, m_ratio, "ratio");
        chk(cur_tag, unsup, m_unsup, "unsup");
    endtask

    task automatic hold(string tag, logic a, logic l, int f, logic [2:0] c, int n);
        cur_tag = tag;
        auto_en = a; lock = l; fs = 8'(f); code = c;
        for (int i = 0; i < n; i++) begin
            base_tick = 1'b1;
            cycle();
        end
    endtask

    initial begin
        #(8 * 200000);
        n_errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240607));
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11", ratio, 0, "ratio in reset");
        chk("R11", bck, 0, "bck in reset");
        chk("R11", lrck, 0, "lrck in reset");
        chk("R11", unsup, 0, "unsup in reset");
        chk("R11", sck_tick, 0, "sck in reset");
        rst_n = 1'b1;
        @(negedge clk);

        // Directed band, range and code corners, each held beyond one frame.
        hold("R1", 1, 1, 54, 3'b000, 1100);
        hold("R1", 1, 1, 55, 3'b000, 1100);
        hold("R1", 1, 1, 107, 3'b000, 1100);
        hold("R1", 1, 1, 108, 3'b000, 1100);
        hold("R2", 1, 0, 44, 3'b010, 1100);
        hold("R3", 1, 1, 200, 3'b100, 1100);
        hold("R4", 0, 1, 200, 3'b010, 1100);
        hold("R4", 0, 1, 48, 3'b001, 1100);
        hold("R4", 0, 1, 48, 3'b111, 1100);
        hold("R5", 0, 1, 108, 3'b100, 1100);
        hold("R5", 0, 1, 109, 3'b100, 1100);
        hold("R6", 1, 1, 6, 3'b000, 600);
        hold("R6", 1, 1, 7, 3'b000, 600);
        hold("R6", 1, 1, 216, 3'b000, 600);
        hold("R6", 1, 1, 217, 3'b000, 600);
        hold("R6", 1, 0, 250, 3'b000, 600);

        // Constrained random: sparse base ticks, changing settings mid-frame.
        cur_tag = "R7";
        for (int seg = 0; seg < 60; seg++) begin
            int len;
            int sel;
            len = 100 + int'($urandom_range(900));
            auto_en = $urandom_range(1);
            lock = ($urandom_range(3) != 0);
            sel = int'($urandom_range(3));
            case (sel)
                0: fs = 8'($urandom_range(60, 40));
                1: fs = 8'($urandom_range(115, 100));
                2: fs = 8'($urandom_range(20, 0));
                default: fs = 8'($urandom_range(255, 190));
            endcase
            code = 3'($urandom_range(7));
            for (int i = 0; i < len; i++) begin
                base_tick = ($urandom_range(9) < 8);
                cycle();
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule